// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models the command side of a parallel NOR flash. A host drives a byte address, a 16-bit data word and single-cycle read and write strobes. Writes do not go straight into storage. A cycle-counted sequencer decodes the low byte of each write as a command or as an argument to the command before it. The sequencer then programs one word, erases one sector, fills a run of words in a buffered write, changes the status register, or switches the read mode.

The read mode decides what a read returns. It can return the stored word, the 8-bit status register, the manufacturer or device code, or a byte from a computed query table. Read data is registered, appears one cycle after the read strobe, and holds until the next read. The storage is a word array split into uniform sectors; the address width and the sector width are parameters. Only status bit 7 (ready) is ever set.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset the status register is 0x00, `rdata` is 0x0000 and the sequencer waits for a command.
- R2: A command byte of 0x10 or 0x40 arms a program. The next write stores its full 16-bit data at its address, sets status bit 7 and leaves the device in array read.
- R3: A command byte of 0x20 followed by 0xD0 erases the whole sector that holds the second write's address (aligned down), setting every word to 0xFFFF. It sets status bit 7 and leaves other sectors unchanged.
- R4: After 0x20, a second write of 0xFF, or of any value other than 0xD0, erases nothing and returns to array read.
- R5: 0xE8 starts a buffered write and sets status bit 7. The next write's full 16-bit value is the word count N, with 1 <= N <= MAX_WORDS. The following N writes store their data at their own addresses, and a further write of 0xD0 completes the operation. N = MAX_WORDS is accepted.
- R6: A word count of 0 or above MAX_WORDS is rejected. The device returns to array read and the following write is decoded as a new command.
- R7: 0x60 followed by 0x01 or 0xD0 sets status bit 7 and returns to command decode with status reads. 0x60 followed by 0xFF, or by any other value, returns to array read.
- R8: A command byte of 0x50 clears the status register to 0x00. A command byte of 0xFF selects array read.
- R9: After the commands 0x20, 0x50, 0x60, 0x70 or 0xE8, every read returns the status register zero-extended, whatever the address.
- R10: After 0x90, a read at low address byte 0x00 returns MFR_CODE, at 0x01 returns DEV_CODE, and at any other offset returns 0x0000.
- R11: After 0x98, a read returns, zero-extended, the query byte indexed by address bits [7:0]. Indices 0x10..0x12 hold 0x51, 0x52, 0x59. Index 0x27 holds ADDR_W, 0x2A holds log2 of the buffer size in bytes, 0x2D holds the sector count minus one and 0x2F holds the sector size divided by 256. Indices at or past 0x3D return 0.
- R12: An unrecognised command byte selects array read.
- R13: `rdata` updates on the cycle after `rd_en` and holds its value while `rd_en` is low.
- R14: In the buffered-write confirm cycle, a value other than 0xD0 returns to array read (already stored words stay).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | ADDR_W | Byte address for reads and writes (bit 0 is ignored for storage) |
| wdata | input | 16 | Write data; command byte in bits [7:0] |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| rdata | output | 16 | Registered read data |

## Verification
The bench erases through an address that is not sector aligned and checks both ends of the sector. It also checks that the neighbouring sector keeps its data; a design that misaligned the erase would leave the edge words unchanged or wipe the wrong sector. It aborts erase, lock and buffered sequences with 0xFF and with stray values, then reads the array back; a design that fell through into the status mode would return 0x0080 instead of data. Buffered writes are run with N = 1, N = MAX_WORDS, N = 0 and N = MAX_WORDS + 1. An off-by-one counter would swallow the confirm word or store one word too many. A design that failed to reject a bad count would store the next write as data.

// File: rtl/nor_pkg.sv
package nor_pkg;

  typedef enum logic [2:0] {
    PH_CMD, PH_PROG, PH_ERASE, PH_LOCK, PH_COUNT, PH_FILL, PH_CONFIRM
  } phase_t;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_ID, RM_QUERY} rmode_t;

  localparam logic [7:0] OP_PROG_A  = 8'h10;
  localparam logic [7:0] OP_PROG_B  = 8'h40;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CLRSTS  = 8'h50;
  localparam logic [7:0] OP_LOCK    = 8'h60;
  localparam logic [7:0] OP_RDSTS   = 8'h70;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_BUFWR   = 8'hE8;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_SETLOCK = 8'h01;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] QUERY_LEN  = 8'h3D;

  // Query byte computed from geometry; zero past the end of the table.
  function automatic logic [7:0] query_byte(input logic [7:0] idx, input int addr_w,
                                            input int nsect, input int sect_bytes,
                                            input int buf_log2);
    logic [7:0] b;
    b = 8'h00;
    case (idx)
      8'h10: b = 8'h51;
      8'h11: b = 8'h52;
      8'h12: b = 8'h59;
      8'h13: b = 8'h01;
      8'h15: b = 8'h31;
      8'h1B: b = 8'h45;
      8'h1C: b = 8'h55;
      8'h1F: b = 8'h07;
      8'h20: b = 8'h07;
      8'h21: b = 8'h0A;
      8'h23: b = 8'h04;
      8'h24: b = 8'h04;
      8'h25: b = 8'h04;
      8'h27: b = 8'(addr_w);
      8'h28: b = 8'h02;
      8'h2A: b = 8'(buf_log2);
      8'h2C: b = 8'h01;
      8'h2D: b = 8'(nsect - 1);
      8'h2E: b = 8'((nsect - 1) >> 8);
      8'h2F: b = 8'(sect_bytes >> 8);
      8'h30: b = 8'(sect_bytes >> 16);
      8'h31: b = 8'h50;
      8'h32: b = 8'h52;
      8'h33: b = 8'h49;
      8'h34: b = 8'h31;
      8'h35: b = 8'h31;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/nor_word_array.sv
module nor_word_array #(
  parameter int ADDR_W = 12,
  parameter int SECT_W = 9
) (
  input  logic              clk,
  input  logic              prog_en,
  input  logic              erase_en,
  input  logic [ADDR_W-2:0] word_addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rd_word
);
  localparam int NSECT = 1 << (ADDR_W - SECT_W);
  localparam int WPS   = 1 << (SECT_W - 1);

  logic [15:0] mem [NSECT][WPS];
  logic [ADDR_W-SECT_W-1:0] sect;
  logic [SECT_W-2:0]        word;

  assign sect = word_addr[ADDR_W-2:SECT_W-1];
  assign word = word_addr[SECT_W-2:0];

  // Storage carries no reset; erase fills a whole sector in one cycle.
  always_ff @(posedge clk) begin
    if (erase_en) begin
      for (int w = 0; w < WPS; w++) mem[sect][w] <= 16'hFFFF;
    end else if (prog_en) begin
      mem[sect][word] <= wdata;
    end
  end

  assign rd_word = mem[sect][word];
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_pkg::*;
#(
  parameter int MAX_WORDS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output rmode_t      rmode,
  output logic [7:0]  status,
  output logic        prog_en,
  output logic        erase_en
);
  localparam int          CW   = $clog2(MAX_WORDS + 1);
  localparam logic [15:0] MAXW = 16'(MAX_WORDS);

  phase_t          phase_q, phase_n;
  rmode_t          rmode_q, rmode_n;
  logic [7:0]      status_q, status_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [7:0]      cb;

  assign cb = wr_data[7:0];

  always_comb begin
    phase_n  = phase_q;
    rmode_n  = rmode_q;
    status_n = status_q;
    cnt_n    = cnt_q;
    prog_en  = 1'b0;
    erase_en = 1'b0;
    if (wr_en) begin
      unique case (phase_q)
        PH_CMD: begin
          case (cb)
            OP_PROG_A, OP_PROG_B: begin phase_n = PH_PROG; rmode_n = RM_ARRAY; end
            OP_ERASE:  begin phase_n = PH_ERASE; rmode_n = RM_STATUS; end
            OP_CLRSTS: begin status_n = 8'h00; rmode_n = RM_STATUS; end
            OP_LOCK:   begin phase_n = PH_LOCK; rmode_n = RM_STATUS; end
            OP_RDSTS:  rmode_n = RM_STATUS;
            OP_IDENT:  rmode_n = RM_ID;
            OP_QUERY:  rmode_n = RM_QUERY;
            OP_BUFWR:  begin
              phase_n  = PH_COUNT;
              rmode_n  = RM_STATUS;
              status_n = status_q | 8'h80;
            end
            default:   rmode_n = RM_ARRAY;
          endcase
        end
        PH_PROG: begin
          prog_en  = 1'b1;
          status_n = status_q | 8'h80;
          rmode_n  = RM_ARRAY;
          phase_n  = PH_CMD;
        end
        PH_ERASE: begin
          phase_n = PH_CMD;
          if (cb == OP_CONFIRM) begin
            erase_en = 1'b1;
            status_n = status_q | 8'h80;
          end else begin
            rmode_n = RM_ARRAY;
          end
        end
        PH_LOCK: begin
          phase_n = PH_CMD;
          if (cb == OP_SETLOCK || cb == OP_CONFIRM) status_n = status_q | 8'h80;
          else rmode_n = RM_ARRAY;
        end
        PH_COUNT: begin
          if (wr_data != 16'h0000 && wr_data <= MAXW) begin
            cnt_n   = wr_data[CW-1:0];
            phase_n = PH_FILL;
          end else begin
            phase_n = PH_CMD;
            rmode_n = RM_ARRAY;
          end
        end
        PH_FILL: begin
          prog_en = 1'b1;
          cnt_n   = cnt_q - CW'(1);
          if (cnt_q == CW'(1)) phase_n = PH_CONFIRM;
        end
        PH_CONFIRM: begin
          phase_n = PH_CMD;
          if (cb != OP_CONFIRM) rmode_n = RM_ARRAY;
        end
        default: begin
          phase_n = PH_CMD;
          rmode_n = RM_ARRAY;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_CMD;
      rmode_q  <= RM_ARRAY;
      status_q <= 8'h00;
      cnt_q    <= '0;
    end else if (wr_en) begin
      phase_q  <= phase_n;
      rmode_q  <= rmode_n;
      status_q <= status_n;
      cnt_q    <= cnt_n;
    end
  end

  assign rmode  = rmode_q;
  assign status = status_q;

  assert_prog_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && phase_q == PH_PROG) |=> (status_q[7] && rmode_q == RM_ARRAY && phase_q == PH_CMD));

  assert_erase_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> status_q[7]);

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FILL) |-> (cnt_q != '0 && cnt_q <= CW'(MAX_WORDS)));

  assert_bad_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && phase_q == PH_COUNT && (wr_data == 16'h0000 || wr_data > MAXW))
      |=> (phase_q == PH_CMD && rmode_q == RM_ARRAY));

  assert_clear_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && phase_q == PH_CMD && wr_data[7:0] == OP_CLRSTS) |=> (status_q == 8'h00));
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
  import nor_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          SECT_W    = 9,
  parameter int          MAX_WORDS = 32,
  parameter logic [15:0] MFR_CODE  = 16'h0089,
  parameter logic [15:0] DEV_CODE  = 16'h0017
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [15:0]       rdata
);
  localparam int NSECT     = 1 << (ADDR_W - SECT_W);
  localparam int SECT_B    = 1 << SECT_W;
  localparam int BUF_LOG2  = $clog2(MAX_WORDS * 2);

  logic [1:0]  rst_sync;
  logic        rst_n_s;
  rmode_t      rmode;
  logic [7:0]  status;
  logic        prog_en, erase_en;
  logic [15:0] arr_word, rd_next, rdata_q;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  nor_cmd_seq #(.MAX_WORDS(MAX_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_data(wdata),
    .rmode(rmode), .status(status), .prog_en(prog_en), .erase_en(erase_en)
  );

  nor_word_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
    .clk(clk), .prog_en(prog_en), .erase_en(erase_en),
    .word_addr(addr[ADDR_W-1:1]), .wdata(wdata), .rd_word(arr_word)
  );

  always_comb begin
    unique case (rmode)
      RM_STATUS: rd_next = {8'h00, status};
      RM_ID: begin
        if (addr[7:0] == 8'h00)      rd_next = MFR_CODE;
        else if (addr[7:0] == 8'h01) rd_next = DEV_CODE;
        else                         rd_next = 16'h0000;
      end
      RM_QUERY: rd_next = {8'h00, query_byte(addr[7:0], ADDR_W, NSECT, SECT_B, BUF_LOG2)};
      default:  rd_next = arr_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   rdata_q <= 16'h0000;
    else if (rd_en) rdata_q <= rd_next;
  end
  assign rdata = rdata_q;

  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_en |=> $stable(rdata_q));

  assert_status_idle_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && rmode == RM_STATUS) |=> (rdata_q[15:8] == 8'h00));
endmodule

// File: tb/nor_cmd_engine_test.sv
module nor_cmd_engine_test;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [15:0]   wdata;
  logic          wr_en, rd_en;
  logic [15:0]   rdata;

  int tests = 0;
  int fails = 0;
  logic [15:0] got;

  always #10 clk = ~clk;

  nor_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata)
  );

  function automatic logic [32:0] w(input logic [11:0] a, input logic [15:0] d);
    return {1'b0, a, d, 4'd0};
  endfunction
  function automatic logic [32:0] r(input logic [11:0] a, input logic [15:0] e, input logic [3:0] q);
    return {1'b1, a, e, q};
  endfunction

  localparam int NV = 54;
  localparam logic [32:0] VEC [NV] = '{
    w(12'h000,16'h0020), w(12'h010,16'h00D0), r(12'h000,16'h0080,4'd9),     // R3 erase, R9 status
    w(12'h000,16'h00FF), r(12'h1FE,16'hFFFF,4'd3), r(12'h000,16'hFFFF,4'd3), // R3 whole sector
    w(12'h200,16'h0020), w(12'h2AA,16'h00D0), w(12'h000,16'h00FF),
    r(12'h3FE,16'hFFFF,4'd3),
    w(12'h000,16'h0050), w(12'h000,16'h0040), w(12'h004,16'h1234),          // R2 program
    r(12'h004,16'h1234,4'd2), w(12'h000,16'h0070), r(12'h000,16'h0080,4'd2),
    w(12'h000,16'h0050), r(12'h000,16'h0000,4'd8),                          // R8 clear
    w(12'h000,16'h0010), w(12'h206,16'hBEEF), r(12'h206,16'hBEEF,4'd2),
    w(12'h200,16'h0020), w(12'h200,16'h00FF), r(12'h206,16'hBEEF,4'd4),     // R4 cancel
    w(12'h200,16'h0020), w(12'h200,16'h0055), r(12'h206,16'hBEEF,4'd4),
    w(12'h3F0,16'h0020), w(12'h3F0,16'h00D0), w(12'h000,16'h00FF),
    r(12'h206,16'hFFFF,4'd3), r(12'h004,16'h1234,4'd3),                      // R3 neighbour kept
    w(12'h000,16'h0050), w(12'h100,16'h00E8), r(12'h100,16'h0080,4'd5),     // R5 buffered
    w(12'h100,16'h0003), w(12'h100,16'hAAAA), w(12'h102,16'hBBBB),
    w(12'h104,16'hCCCC), r(12'h000,16'h0080,4'd5), w(12'h000,16'h00D0),
    w(12'h000,16'h00FF), r(12'h100,16'hAAAA,4'd5), r(12'h102,16'hBBBB,4'd5),
    r(12'h104,16'hCCCC,4'd5), r(12'h106,16'hFFFF,4'd5),
    w(12'h180,16'h00E8), w(12'h180,16'h0021), w(12'h180,16'h5A5A),          // R6 too many
    r(12'h180,16'hFFFF,4'd6),
    w(12'h000,16'h00E8), w(12'h000,16'h0000), w(12'h182,16'h1111),          // R6 zero
    r(12'h182,16'hFFFF,4'd6)
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic rchk(input int req, input logic [11:0] a, input logic [15:0] e);
    logic [15:0] v;
    rd(a, v);
    check(req, v, e);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(1, rdata, 16'h0000);                     // R1 rdata after reset
    wr(12'h000, 16'h0070);
    rchk(1, 12'h000, 16'h0000);                    // R1 status after reset

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32]) rchk(int'(VEC[i][3:0]), VEC[i][31:20], VEC[i][19:4]);
      else            wr(VEC[i][31:20], VEC[i][19:4]);
    end

    // R14: confirm cycle with a wrong value
    wr(12'h1E0, 16'h00E8); wr(12'h1E0, 16'h0001); wr(12'h1E0, 16'h4242);
    wr(12'h1E0, 16'h0011);
    rchk(14, 12'h1E0, 16'h4242);

    // R5: count at the limit
    wr(12'h200, 16'h00E8); wr(12'h200, 16'h0020);
    for (int i = 0; i < 32; i++) wr(12'(12'h200 + 2 * i), 16'(16'hC000 + i));
    wr(12'h200, 16'h00D0); wr(12'h000, 16'h00FF);
    rchk(5, 12'h200, 16'hC000);
    rchk(5, 12'h23E, 16'hC01F);
    rchk(5, 12'h240, 16'hFFFF);

    // R7: lock control
    wr(12'h000, 16'h0050); wr(12'h000, 16'h0060); wr(12'h000, 16'h0001);
    rchk(7, 12'h000, 16'h0080);
    wr(12'h000, 16'h0050); wr(12'h000, 16'h0060); wr(12'h000, 16'h00D0);
    rchk(7, 12'h004, 16'h0080);
    wr(12'h000, 16'h0060); wr(12'h000, 16'h00FF);
    rchk(7, 12'h004, 16'h1234);
    wr(12'h000, 16'h0060); wr(12'h000, 16'h0022);
    rchk(7, 12'h004, 16'h1234);

    // R10: identifier codes
    wr(12'h000, 16'h0090);
    rchk(10, 12'h000, 16'h0089);
    rchk(10, 12'h001, 16'h0017);
    rchk(10, 12'h002, 16'h0000);

    // R11: query bytes
    wr(12'h000, 16'h0098);
    rchk(11, 12'h010, 16'h0051);
    rchk(11, 12'h011, 16'h0052);
    rchk(11, 12'h012, 16'h0059);
    rchk(11, 12'h027, 16'h000C);
    rchk(11, 12'h02A, 16'h0006);
    rchk(11, 12'h02D, 16'h0007);
    rchk(11, 12'h02F, 16'h0002);
    rchk(11, 12'h080, 16'h0000);
    rchk(11, 12'h110, 16'h0051);

    // R12: unknown command
    wr(12'h000, 16'h0033);
    rchk(12, 12'h004, 16'h1234);

    // R9: status read ignores address
    wr(12'h000, 16'h0070);
    rchk(9, 12'h004, 16'h0080);
    wr(12'h000, 16'h00FF);

    // R13: latency and hold
    rchk(13, 12'h004, 16'h1234);
    @(negedge clk); addr = 12'h206;
    repeat (3) @(negedge clk);
    check(13, rdata, 16'h1234);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule